// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block maps every CPU address onto a target unit through eight windows that software sets up. Each window holds an enable, a 4-bit target unit ID, an 8-bit attribute, a size and a base address, all at 64 KB granularity. The first four windows also hold a remap base and a 32-bit upper address word, so a region seen by the CPU can land at a different place in the target's address space.

Software programs the windows through a small word-wide register port and can read every register back. On the decode side the block takes one CPU address and, in the same cycle, returns a hit flag, the target ID, the attribute, the translated address and the upper address word of the winning window. When enabled windows overlap, the lowest-numbered one wins. When no window matches, every decode output is zero.

Top module: `addr_window_decoder`

## Requirements
- R1: There are eight windows, each with a 16-byte register group at byte offset window*16 on `reg_addr`. Within a group the control register is at 0x0, the base at 0x4, the remap base at 0x8 and the remap upper word at 0xC. `reg_rdata` shows the register that `reg_addr` selects, in the same cycle.
- R2: Control register fields: bit 0 enables the window, bits 7:4 hold the target ID, bits 15:8 hold the attribute, and bits 31:16 hold (size-1)>>16. Bits 3:1 are not stored and read as zero.
- R3: The base and the remap base keep only bits 31:16 and read bits 15:0 as zero. The remap upper word keeps all 32 bits.
- R4: Windows 4 to 7 have no remap registers. Writes to their offsets 0x8 and 0xC are ignored, and reads of those offsets return zero. A hit on one of these windows outputs the CPU address unchanged and an upper word of zero.
- R5: Reset is synchronous and active-low. It clears every register of every window, so after reset all registers read zero and no address hits.
- R6: An address hits a window when the window is enabled and address bits 31:16, ANDed with the inverted size field, equal the stored base bits 31:16.
- R7: When several enabled windows hit, the lowest-numbered window supplies all decode outputs.
- R8: On windows 0 to 3 the translated address is (addr AND keep) OR (remap AND NOT keep), where keep = {size field, 16'hFFFF}. The upper address output is the window's remap upper word.
- R9: If no window hits, `dec_hit` is 0 and the target, attribute, translated address and upper address outputs are all 0.
- R10: Decoding is combinational from `cpu_addr` and the registers. A register write takes effect at the rising clock edge where `reg_we` is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address: window in bits 6:4, register in bits 3:2 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register selected by `reg_addr` |
| cpu_addr | input | 32 | CPU address to decode |
| dec_hit | output | 1 | Some enabled window matched |
| dec_target | output | 4 | Target unit ID of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_addr | output | 32 | Translated address |
| dec_addr_hi | output | 32 | Upper address word for 64-bit targets |

## Verification
The decoder is driven with addresses at the first and last bytes of windows of different sizes, and with addresses one page past a window's end. These show whether the size mask is applied to the right bits. Some addresses fall where a small remapping window overlaps a larger pass-through window, which separates priority order from plain match order. Disabling the low window afterwards shows the high window taking over. A window with a zero remap base, a window whose remap equals its base, and a non-remapping window show that translation applies only where it should. Writes are checked on both sides of the clock edge to pin down when they take effect.

// File: rtl/awd_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register offset codes and the per-window
// configuration record of the address window decoder.
// Assumes 32-bit CPU addresses and a 64 KB window granule.
package awd_pkg;
    localparam int ADDR_W  = 32;
    localparam int GRAN_W  = 16;                 // log2 of the 64 KB granule
    localparam int PAGE_W  = ADDR_W - GRAN_W;    // stored address bits
    localparam int TGT_W   = 4;
    localparam int ATTR_W  = 8;
    localparam int GROUP_W = 4;                  // 16-byte register group

    // Register selector, taken from byte offset bits 3:2 within a group
    typedef enum logic [1:0] {
        OFS_CTRL  = 2'd0,
        OFS_BASE  = 2'd1,
        OFS_RLO   = 2'd2,
        OFS_RHI   = 2'd3
    } reg_ofs_e;

    // Decoded configuration of one window
    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [PAGE_W-1:0] size_m1;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] remap_lo;
        logic [ADDR_W-1:0] remap_hi;
    } win_cfg_t;
endpackage

// File: rtl/awd_win_regs.sv
`timescale 1ns/1ps
// Module: register group of one decode window.
// Holds control and base, plus the remap pair when HAS_REMAP is set.
// Assumes the parent decodes the window index and gives a qualified write.
module awd_win_regs
    import awd_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_ofs_e          ofs,
    input  logic [ADDR_W-1:0] wdata,
    output win_cfg_t          cfg,
    output logic [ADDR_W-1:0] rdata
);
    logic              en_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [ATTR_W-1:0] attr_q;
    logic [PAGE_W-1:0] size_q;
    logic [PAGE_W-1:0] base_q;
    logic [PAGE_W-1:0] rlo_q;
    logic [ADDR_W-1:0] rhi_q;

    // Purpose: control and base storage, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            tgt_q  <= '0;
            attr_q <= '0;
            size_q <= '0;
            base_q <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_CTRL) begin
                en_q   <= wdata[0];
                tgt_q  <= wdata[7:4];
                attr_q <= wdata[15:8];
                size_q <= wdata[ADDR_W-1:GRAN_W];
            end
            if (ofs == OFS_BASE) begin
                base_q <= wdata[ADDR_W-1:GRAN_W];
            end
        end
    end

    generate
        if (HAS_REMAP) begin : g_remap
            // Purpose: remap base and upper word storage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rlo_q <= '0;
                    rhi_q <= '0;
                end else if (wr_en) begin
                    if (ofs == OFS_RLO) rlo_q <= wdata[ADDR_W-1:GRAN_W];
                    if (ofs == OFS_RHI) rhi_q <= wdata;
                end
            end
        end else begin : g_noremap
            assign rlo_q = '0;
            assign rhi_q = '0;
        end
    endgenerate

    assign cfg = '{en: en_q, tgt: tgt_q, attr: attr_q, size_m1: size_q,
                   base: base_q, remap_lo: rlo_q, remap_hi: rhi_q};

    // Purpose: readback of the selected register, unused low bits as zero
    always_comb begin
        unique case (ofs)
            OFS_CTRL: rdata = {size_q, attr_q, tgt_q, 3'b000, en_q};
            OFS_BASE: rdata = {base_q, {GRAN_W{1'b0}}};
            OFS_RLO:  rdata = {rlo_q, {GRAN_W{1'b0}}};
            OFS_RHI:  rdata = rhi_q;
            default:  rdata = '0;
        endcase
    end

    // R2: a control write lands in the fields on the next edge
    a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_CTRL) |=>
            (cfg.en == $past(wdata[0]) && cfg.tgt == $past(wdata[7:4]) &&
             cfg.attr == $past(wdata[15:8]) &&
             cfg.size_m1 == $past(wdata[ADDR_W-1:GRAN_W])));

    // R10: without a write the configuration holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(cfg));
endmodule

// File: rtl/awd_win_match.sv
`timescale 1ns/1ps
// Module: match and address translation for one window.
// Purely combinational; the size field masks address bits 31:16.
// Assumes base and remap are stored as 64 KB page numbers.
module awd_win_match
    import awd_pkg::*;
#(
    parameter bit HAS_REMAP = 1'b1
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat,
    output logic [ADDR_W-1:0] xlat_hi
);
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] keep;

    assign page = addr[ADDR_W-1:GRAN_W];
    assign keep = {cfg.size_m1, {GRAN_W{1'b1}}};

    // Purpose: window hit on the masked page number
    always_comb begin
        hit = cfg.en && ((page & ~cfg.size_m1) == cfg.base);
    end

    generate
        if (HAS_REMAP) begin : g_xlat
            // Purpose: splice the in-window offset onto the remap base
            always_comb begin
                xlat    = (addr & keep) | ({cfg.remap_lo, {GRAN_W{1'b0}}} & ~keep);
                xlat_hi = cfg.remap_hi;
            end
        end else begin : g_pass
            // Purpose: non-remapping window passes the address through
            always_comb begin
                xlat    = addr;
                xlat_hi = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/awd_prio_sel.sv
`timescale 1ns/1ps
// Module: fixed-priority selection among window hits.
// The lowest-numbered hitting window drives every output; no hit gives zeros.
module awd_prio_sel
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_IW = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  win_cfg_t [NUM_WIN-1:0]         cfg,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_hi,
    output logic                           any_hit,
    output logic [WIN_IW-1:0]              win_idx,
    output logic [TGT_W-1:0]               tgt,
    output logic [ATTR_W-1:0]              attr,
    output logic [ADDR_W-1:0]              out_addr,
    output logic [ADDR_W-1:0]              out_hi
);
    // Purpose: scan upward and keep the first hit
    always_comb begin
        any_hit  = 1'b0;
        win_idx  = '0;
        tgt      = '0;
        attr     = '0;
        out_addr = '0;
        out_hi   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit  = 1'b1;
                win_idx  = WIN_IW'(i);
                tgt      = cfg[i].tgt;
                attr     = cfg[i].attr;
                out_addr = xlat[i];
                out_hi   = xlat_hi[i];
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
// Module: top of the programmable CPU address window decoder.
// Instantiates one register group and one matcher per window, the
// lower NUM_REMAP windows with remap support, and a priority selector.
// Assumes word-aligned register accesses; reg_addr bits 1:0 are ignored.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_REMAP = 4,
    localparam int WIN_IW   = $clog2(NUM_WIN),
    localparam int REG_AW   = WIN_IW + GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              dec_hit,
    output logic [TGT_W-1:0]  dec_target,
    output logic [ATTR_W-1:0] dec_attr,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [ADDR_W-1:0] dec_addr_hi
);
    logic [WIN_IW-1:0]              reg_win;
    reg_ofs_e                       reg_ofs;
    win_cfg_t [NUM_WIN-1:0]         cfg;
    logic [NUM_WIN-1:0][ADDR_W-1:0] rdata_win;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xlat;
    logic [NUM_WIN-1:0][ADDR_W-1:0] xlat_hi;
    logic [WIN_IW-1:0]              win_idx;

    assign reg_win = reg_addr[REG_AW-1:GROUP_W];
    assign reg_ofs = reg_ofs_e'(reg_addr[3:2]);

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            localparam bit REMAP = (w < NUM_REMAP);
            awd_win_regs #(.HAS_REMAP(REMAP)) i_regs (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (reg_we && (reg_win == WIN_IW'(w))),
                .ofs   (reg_ofs),
                .wdata (reg_wdata),
                .cfg   (cfg[w]),
                .rdata (rdata_win[w])
            );
            awd_win_match #(.HAS_REMAP(REMAP)) i_match (
                .cfg     (cfg[w]),
                .addr    (cpu_addr),
                .hit     (hit_vec[w]),
                .xlat    (xlat[w]),
                .xlat_hi (xlat_hi[w])
            );
        end
    endgenerate

    // Purpose: readback mux over the window groups
    always_comb begin
        reg_rdata = rdata_win[reg_win];
    end

    awd_prio_sel #(.NUM_WIN(NUM_WIN)) i_prio (
        .hit_vec  (hit_vec),
        .cfg      (cfg),
        .xlat     (xlat),
        .xlat_hi  (xlat_hi),
        .any_hit  (dec_hit),
        .win_idx  (win_idx),
        .tgt      (dec_target),
        .attr     (dec_attr),
        .out_addr (dec_addr),
        .out_hi   (dec_addr_hi)
    );

    // R5: the cycle after a reset edge nothing can hit
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !dec_hit);

    // R9: a miss drives every decode output to zero
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> (dec_target == '0 && dec_attr == '0 &&
                      dec_addr == '0 && dec_addr_hi == '0));

    // R7: the winner hits and no lower window hits
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> (hit_vec[win_idx] &&
                     ((hit_vec & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0)));

    // R4: non-remapping winners pass the address through
    a_r4_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && int'(win_idx) >= NUM_REMAP) |->
            (dec_addr == cpu_addr && dec_addr_hi == '0));

    // R4: remap offsets of non-remapping windows read zero
    a_r4_remap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_win) >= NUM_REMAP && reg_addr[3]) |-> reg_rdata == '0);

    // R8: translation never alters the offset inside the 64 KB granule
    a_r8_low_offset: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> dec_addr[GRAN_W-1:0] == cpu_addr[GRAN_W-1:0]);

    // R3: base and remap base readback has a zero low half
    a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ofs == OFS_BASE || reg_ofs == OFS_RLO) |->
            reg_rdata[GRAN_W-1:0] == '0);
endmodule

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
// Bench: table-driven decode checks, then directed register, timing,
// priority and reset checks.
module test_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic        dec_hit;
    logic [3:0]  dec_target;
    logic [7:0]  dec_attr;
    logic [31:0] dec_addr;
    logic [31:0] dec_addr_hi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .dec_hit(dec_hit), .dec_target(dec_target), .dec_attr(dec_attr),
        .dec_addr(dec_addr), .dec_addr_hi(dec_addr_hi)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        hit;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [31:0] x;
        logic [31:0] hi;
    } vec_t;

    // Window plan: 0 1MB@8000_0000->C000_0000 hi 1; 1 256MB@9000_0000 self-remap;
    // 2 64KB@F900_0000 remap 0; 3 128KB@4000_0000->1234_0000 hi DEADBEEF;
    // 4 16MB@8000_0000 no remap; 7 programmed but disabled at 3000_0000.
    localparam vec_t VEC [12] = '{
        '{32'h8001_2345, 1'b1, 4'h4, 8'hE0, 32'hC001_2345, 32'h0000_0001},
        '{32'h800F_FFFF, 1'b1, 4'h4, 8'hE0, 32'hC00F_FFFF, 32'h0000_0001},
        '{32'h8010_0000, 1'b1, 4'h2, 8'h3E, 32'h8010_0000, 32'h0},
        '{32'h80FF_FFFC, 1'b1, 4'h2, 8'h3E, 32'h80FF_FFFC, 32'h0},
        '{32'h8100_0000, 1'b0, 4'h0, 8'h00, 32'h0,         32'h0},
        '{32'h9ABC_DEF0, 1'b1, 4'h4, 8'hE8, 32'h9ABC_DEF0, 32'h0},
        '{32'hF900_1234, 1'b1, 4'h1, 8'h2F, 32'h0000_1234, 32'h0},
        '{32'hF901_0000, 1'b0, 4'h0, 8'h00, 32'h0,         32'h0},
        '{32'h4001_ABCD, 1'b1, 4'h3, 8'h11, 32'h1235_ABCD, 32'hDEAD_BEEF},
        '{32'h4002_0000, 1'b0, 4'h0, 8'h00, 32'h0,         32'h0},
        '{32'h3000_0010, 1'b0, 4'h0, 8'h00, 32'h0,         32'h0},
        '{32'h0000_0000, 1'b0, 4'h0, 8'h00, 32'h0,         32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int win, input int ofs, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 7'(win * 16 + ofs);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int win, input int ofs, input logic [31:0] exp);
        reg_addr = 7'(win * 16 + ofs);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic dec_chk(input string req, input vec_t v);
        cpu_addr = v.a;
        #1;
        chk({req, " hit"}, 32'(dec_hit), 32'(v.hit));
        chk({req, " target"}, 32'(dec_target), 32'(v.tgt));
        chk({req, " attr"}, 32'(dec_attr), 32'(v.attr));
        chk({req, " addr"}, dec_addr, v.x);
        chk({req, " addr_hi"}, dec_addr_hi, v.hi);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: every register reads zero after reset, nothing hits
        for (int w = 0; w < 8; w++)
            for (int o = 0; o < 16; o += 4)
                rd_chk("R5 reset readback", w, o, 32'h0);
        dec_chk("R5 reset decode", '{32'h0, 1'b0, 4'h0, 8'h0, 32'h0, 32'h0});

        // Program the windows (R1 group layout)
        wr(0, 4, 32'h8000_1234); wr(0, 8, 32'hC000_5678); wr(0, 12, 32'h0000_0001);
        wr(0, 0, 32'h000F_E04F);
        wr(1, 4, 32'h9000_0000); wr(1, 8, 32'h9000_0000);
        wr(1, 0, 32'h0FFF_E841);
        wr(2, 4, 32'hF900_0000); wr(2, 0, 32'h0000_2F11);
        wr(3, 4, 32'h4000_0000); wr(3, 8, 32'h1234_0000); wr(3, 12, 32'hDEAD_BEEF);
        wr(3, 0, 32'h0001_1131);
        wr(4, 4, 32'h8000_0000); wr(4, 8, 32'hAAAA_0000); wr(4, 12, 32'h5555_5555);
        wr(4, 0, 32'h00FF_3E21);
        wr(7, 4, 32'h3000_0000); wr(7, 0, 32'h0000_5570);

        // R2: control fields, bits 3:1 dropped
        rd_chk("R2 ctrl readback win0", 0, 0, 32'h000F_E041);
        rd_chk("R2 ctrl readback win7", 7, 0, 32'h0000_5570);
        // R3: low halves cleared, upper word kept whole
        rd_chk("R3 base low half", 0, 4, 32'h8000_0000);
        rd_chk("R3 remap low half", 0, 8, 32'hC000_0000);
        rd_chk("R3 remap upper word", 3, 12, 32'hDEAD_BEEF);
        // R1: group offsets address distinct registers
        rd_chk("R1 win3 base", 3, 4, 32'h4000_0000);
        rd_chk("R1 win3 remap", 3, 8, 32'h1234_0000);
        // R4: remap writes on window 4 ignored
        rd_chk("R4 win4 remap low", 4, 8, 32'h0);
        rd_chk("R4 win4 remap upper", 4, 12, 32'h0);

        // Table walk: R6 match, R7 priority, R8 translation, R9 miss, R4 pass
        for (int i = 0; i < 12; i++)
            dec_chk($sformatf("R6/R7/R8/R9 vector %0d", i), VEC[i]);

        // R10: write visible only after the clock edge
        wr(5, 4, 32'h2000_0000);
        @(negedge clk);
        cpu_addr = 32'h2000_0004;
        reg_addr = 7'(5 * 16);
        reg_wdata = 32'h0000_7761;
        reg_we = 1'b1;
        #1;
        chk("R10 before edge hit", 32'(dec_hit), 32'h0);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        chk("R10 after edge hit", 32'(dec_hit), 32'h1);
        chk("R10 after edge target", 32'(dec_target), 32'h6);
        chk("R10 after edge addr", dec_addr, 32'h2000_0004);

        // R7: disabling window 0 hands its region to window 4
        wr(0, 0, 32'h000F_E040);
        dec_chk("R7 fallback to win4", '{32'h8001_2345, 1'b1, 4'h2, 8'h3E, 32'h8001_2345, 32'h0});

        // R5: reset mid-run clears every register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R5 mid-run ctrl", 3, 0, 32'h0);
        rd_chk("R5 mid-run remap upper", 3, 12, 32'h0);
        dec_chk("R5 mid-run decode", '{32'h4001_ABCD, 1'b0, 4'h0, 8'h0, 32'h0, 32'h0});

        finish_run();
    end
endmodule